// File: doc/BRIEF.md
# Four-Phase Interpolating Chip Filter for I/Q Streams

This block shapes two binary chip streams, one in-phase and one quadrature, into band-limited sample words. Every chip is upsampled by four and passed through a 48-tap lowpass response. Zero-stuffing means only one of every four taps meets a non-zero input. The block therefore keeps twelve chips per channel and uses no multipliers. Each of the twelve chip positions owns a small coefficient RAM. The RAM word is selected by the chip's valid flag, the current output phase and the chip value, and it holds the signed product directly: +h, −h, or zero for an invalid chip.

A single filter core is shared between the two channels. One channel sample takes five clocks: a load step that adds two tap words, then four accumulate steps. Two accumulators run side by side, one over taps 0–5 and one over taps 6–11. Their results pass through one pipeline register and are then added. I and Q take turns through the core, so one chip yields four I and four Q samples in a 40-clock frame. Coefficient words are written through a programming port while the filter is idle.

Top module: `iqInterpFir`

## Requirements
- R1: While reset is held and after it is released with no chip presented, `outI` and `outQ` read zero and `outStb` is low.
- R2: In any cycle with `progEn` high, every tap RAM k whose bit `progTapWe[k]` is set stores `progData` at word `progAddr`.
- R3: While filtering, tap RAM k reads the word addressed by delay stage k of the channel being processed. Address bit 3 is the stage's valid flag, bits 2:1 are the output phase, and bit 0 is the chip bit. The words for bit 0 = 1 hold +h, the words for bit 0 = 0 hold −h, and words 0–7 (invalid) hold zero.
- R4: The phase-p output word of a channel is the sign-extended sum of the twelve tap words selected under R3. This equals the sum over k = 0..11 of x[n−k]·h[p+4k].
- R5: The delay lines move by one stage only on a cycle with `chipStb` high. Stage 0 takes the new chip. Idle cycles leave the stored chips unchanged.
- R6: The cycle in which `chipStb` is sampled high is cycle 0. `outI` shows the phase-p sample from cycle 9+10p and `outQ` from cycle 14+10p, for p = 0..3. `outStb` is high for exactly the one cycle in which `outQ` takes a new value. `outI` never changes in a cycle with `outStb` high.
- R7: Chips presented every 40 cycles are processed back to back, and all eight samples of every chip are correct.
- R8: A chip presented partway through a frame restarts the sequence at phase 0 on the I channel. Samples whose five processing cycles finished by that cycle are still delivered; the unfinished ones are dropped.
- R9: A chip presented with `chipOk` low adds zero to every sample. With all twelve stages invalid, both outputs are zero.
- R10: With `progEn` low, `progTapWe`, `progAddr` and `progData` change no coefficient.
- R11: With every coefficient at full scale (±2047) and every stage valid, the outputs reach ±24564 without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chipStb | input | 1 | New chip pair present this cycle |
| chipOk | input | 1 | The new chips are valid (low: contribute zero) |
| chipI | input | 1 | In-phase chip bit (1 → +1, 0 → −1) |
| chipQ | input | 1 | Quadrature chip bit (1 → +1, 0 → −1) |
| progEn | input | 1 | Programming mode; coefficient writes allowed |
| progAddr | input | 4 | Tap RAM word address for programming |
| progData | input | COEF_W | Coefficient word to write |
| progTapWe | input | 12 | Per-tap write enable |
| outI | output | OUT_W | In-phase output sample, two's complement |
| outQ | output | OUT_W | Quadrature output sample, two's complement |
| outStb | output | 1 | One-cycle pulse when a new I/Q pair is complete |

## Verification
Random coefficients with random valid chips on both channels test that each phase takes its own quarter of the response, and that I and Q read different delay lines through the same core. Back-to-back chips and a chip that cuts a frame short separate correct frame sequencing from a free-running one, and show whether finished slots survive a restart. Runs of invalid chips, writes attempted without programming mode, and full-scale coefficients separately expose a missing zero path, a leaky write enable and a narrow accumulator.

// File: rtl/iqFirPkg.sv
package iqFirPkg;
  // structure of the polyphase core
  localparam int TAP_NUM = 12;             // chip positions (48 taps / 4 phases)
  localparam int HALF    = TAP_NUM / 2;    // taps per accumulator
  localparam int STEPS   = HALF - 1;       // load + (HALF-2) accumulate steps
  localparam int SEL_W   = $clog2(HALF - 2);
  localparam int PH_W    = 2;              // interpolation by 4
  localparam int PHASES  = 1 << PH_W;
  localparam int ADDR_W  = PH_W + 2;       // {valid, phase, chip}

  // address-side control: which phase and which channel is read
  typedef struct packed {
    logic [PH_W-1:0] phase;
    logic            isQ;
  } addrCtrl_t;

  // accumulator-side strobes, one cycle behind the address side
  typedef struct packed {
    logic             ld;
    logic             acc;
    logic [SEL_W-1:0] sel;
    logic             last;
    logic             isQ;
  } accCtrl_t;
endpackage

// File: rtl/iqFirTapRam.sv
module iqFirTapRam #(
  parameter int W  = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/iqFirAccum.sv
module iqFirAccum
  import iqFirPkg::*;
#(
  parameter int COEF_W = 12,
  parameter int ACC_W  = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld,
  input  logic                       acc,
  input  logic [SEL_W-1:0]           sel,
  input  logic [HALF-1:0][COEF_W-1:0] taps,
  output logic [ACC_W-1:0]           sum
);
  localparam int EXT = ACC_W - COEF_W;

  logic [COEF_W-1:0] pick;
  logic [ACC_W-1:0]  ext0, ext1, extPick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < HALF - 2; i++)
      if (sel == SEL_W'(i)) pick = taps[i+2];
  end

  assign ext0    = {{EXT{taps[0][COEF_W-1]}}, taps[0]};
  assign ext1    = {{EXT{taps[1][COEF_W-1]}}, taps[1]};
  assign extPick = {{EXT{pick[COEF_W-1]}}, pick};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (ld)  sum <= ext0 + ext1;
    else if (acc) sum <= sum + extPick;
  end
endmodule

// File: rtl/iqFirCtrl.sv
module iqFirCtrl
  import iqFirPkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      chipStb,
  output addrCtrl_t addrBus,
  output accCtrl_t  accBus
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [STEPS-1:0] ring;     // one-hot step within a channel slot, zero when idle
  logic             isQ;
  logic [PH_W-1:0]  phase;
  logic [SEL_W-1:0] selNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring  <= '0;
      isQ   <= 1'b0;
      phase <= '0;
    end else if (chipStb) begin
      ring  <= STEPS'(1);
      isQ   <= 1'b0;
      phase <= '0;
    end else if (ring[STEPS-1]) begin
      if (isQ && phase == LAST_PH) begin
        ring <= '0;
      end else begin
        ring <= STEPS'(1);
        isQ  <= ~isQ;
        if (isQ) phase <= phase + 1'b1;
      end
    end else begin
      ring <= ring << 1;
    end
  end

  always_comb begin
    selNext = '0;
    for (int i = 1; i < STEPS; i++)
      if (ring[i]) selNext = SEL_W'(i - 1);
  end

  always_comb begin
    addrBus.phase = phase;
    addrBus.isQ   = isQ;
  end

  // RAM read takes one cycle, so accumulator strobes trail the address by one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accBus <= '0;
    end else begin
      accBus.ld   <= ring[0];
      accBus.acc  <= |ring[STEPS-1:1];
      accBus.sel  <= selNext;
      accBus.last <= ring[STEPS-1];
      accBus.isQ  <= isQ;
    end
  end
endmodule

// File: rtl/iqFirDatapath.sv
module iqFirDatapath
  import iqFirPkg::*;
#(
  parameter int COEF_W = 12,
  parameter int ACC_W  = 17,
  parameter int OUT_W  = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chipStb,
  input  logic               chipOk,
  input  logic               chipI,
  input  logic               chipQ,
  input  logic               progEn,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [COEF_W-1:0]  progData,
  input  logic [TAP_NUM-1:0] progTapWe,
  input  addrCtrl_t          addrBus,
  input  accCtrl_t           accBus,
  output logic [OUT_W-1:0]   outI,
  output logic [OUT_W-1:0]   outQ,
  output logic               outStb
);
  localparam int OEXT = OUT_W - ACC_W;

  logic [TAP_NUM-1:0] vI, bI, vQ, bQ;
  logic [TAP_NUM-1:0][COEF_W-1:0] tapOut;
  logic [1:0][ACC_W-1:0] accSum;
  logic capV, capQ;
  logic pipeV, pipeQ;
  logic [ACC_W-1:0] pipeTop, pipeBot;
  logic [OUT_W-1:0] total;

  // chip delay lines, stage 0 newest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vI <= '0; bI <= '0; vQ <= '0; bQ <= '0;
    end else if (chipStb) begin
      vI <= {vI[TAP_NUM-2:0], chipOk};
      bI <= {bI[TAP_NUM-2:0], chipI};
      vQ <= {vQ[TAP_NUM-2:0], chipOk};
      bQ <= {bQ[TAP_NUM-2:0], chipQ};
    end
  end

  for (genvar k = 0; k < TAP_NUM; k++) begin : g_tap
    logic [ADDR_W-1:0] rdAddr, ramAddr;
    assign rdAddr  = addrBus.isQ ? {vQ[k], addrBus.phase, bQ[k]}
                                 : {vI[k], addrBus.phase, bI[k]};
    assign ramAddr = progEn ? progAddr : rdAddr;
    iqFirTapRam #(.W(COEF_W), .AW(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (progEn & progTapWe[k]),
      .addr  (ramAddr),
      .wdata (progData),
      .rdata (tapOut[k])
    );
  end

  for (genvar h = 0; h < 2; h++) begin : g_acc
    iqFirAccum #(.COEF_W(COEF_W), .ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (accBus.ld),
      .acc   (accBus.acc),
      .sel   (accBus.sel),
      .taps  (tapOut[h*HALF +: HALF]),
      .sum   (accSum[h])
    );
  end

  // capture flag lines up with the final accumulator value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capV <= 1'b0;
      capQ <= 1'b0;
    end else begin
      capV <= accBus.last;
      capQ <= accBus.isQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipeV   <= 1'b0;
      pipeQ   <= 1'b0;
      pipeTop <= '0;
      pipeBot <= '0;
    end else begin
      pipeV <= capV;
      if (capV) begin
        pipeQ   <= capQ;
        pipeTop <= accSum[0];
        pipeBot <= accSum[1];
      end
    end
  end

  assign total = {{OEXT{pipeTop[ACC_W-1]}}, pipeTop}
               + {{OEXT{pipeBot[ACC_W-1]}}, pipeBot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outI   <= '0;
      outQ   <= '0;
      outStb <= 1'b0;
    end else begin
      outStb <= pipeV & pipeQ;
      if (pipeV && !pipeQ) outI <= total;
      if (pipeV &&  pipeQ) outQ <= total;
    end
  end
endmodule

// File: rtl/iqInterpFir.sv
module iqInterpFir
  import iqFirPkg::*;
#(
  parameter int COEF_W = 12,
  parameter int ACC_W  = 17,
  parameter int OUT_W  = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chipStb,
  input  logic               chipOk,
  input  logic               chipI,
  input  logic               chipQ,
  input  logic               progEn,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [COEF_W-1:0]  progData,
  input  logic [TAP_NUM-1:0] progTapWe,
  output logic [OUT_W-1:0]   outI,
  output logic [OUT_W-1:0]   outQ,
  output logic               outStb
);
  addrCtrl_t addrBus;
  accCtrl_t  accBus;

  iqFirCtrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .chipStb (chipStb),
    .addrBus (addrBus),
    .accBus  (accBus)
  );

  iqFirDatapath #(.COEF_W(COEF_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .chipStb   (chipStb),
    .chipOk    (chipOk),
    .chipI     (chipI),
    .chipQ     (chipQ),
    .progEn    (progEn),
    .progAddr  (progAddr),
    .progData  (progData),
    .progTapWe (progTapWe),
    .addrBus   (addrBus),
    .accBus    (accBus),
    .outI      (outI),
    .outQ      (outQ),
    .outStb    (outStb)
  );
endmodule

// File: rtl/iqInterpFirChk.sv
module iqInterpFirChk
  import iqFirPkg::*;
#(
  parameter int OUT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chipStb,
  input logic             outStb,
  input logic [OUT_W-1:0] outI,
  input logic [OUT_W-1:0] outQ,
  input logic [PH_W-1:0]  phase,
  input logic             isQ,
  input logic             ld,
  input logic             acc
);
  // R6
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outStb |=> !outStb);

  // R6
  q_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outQ) |-> outStb);

  // R6
  i_apart_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outI) |-> !outStb);

  // R8
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chipStb |=> (phase == '0 && !isQ));

  // R4
  load_acc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld && acc));
endmodule

bind iqInterpFir iqInterpFirChk #(.OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .chipStb (chipStb),
  .outStb  (outStb),
  .outI    (outI),
  .outQ    (outQ),
  .phase   (addrBus.phase),
  .isQ     (addrBus.isQ),
  .ld      (accBus.ld),
  .acc     (accBus.acc)
);

// File: tb/tb_iqInterpFir.sv
module tb_iqInterpFir;
  import iqFirPkg::*;

  localparam int COEF_W = 12;
  localparam int ACC_W  = 17;
  localparam int OUT_W  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chipStb = 1'b0, chipOk = 1'b0, chipI = 1'b0, chipQ = 1'b0;
  logic progEn = 1'b0;
  logic [ADDR_W-1:0]  progAddr = '0;
  logic [COEF_W-1:0]  progData = '0;
  logic [TAP_NUM-1:0] progTapWe = '0;
  logic [OUT_W-1:0]   outI, outQ;
  logic               outStb;

  always #10 clk = ~clk;

  iqInterpFir #(.COEF_W(COEF_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n), .chipStb(chipStb), .chipOk(chipOk),
    .chipI(chipI), .chipQ(chipQ), .progEn(progEn), .progAddr(progAddr),
    .progData(progData), .progTapWe(progTapWe),
    .outI(outI), .outQ(outQ), .outStb(outStb)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench copy of what the coefficient RAMs should hold
  int ramM [TAP_NUM][1 << ADDR_W];
  bit mvI [TAP_NUM], mbI [TAP_NUM], mvQ [TAP_NUM], mbQ [TAP_NUM];

  // two chips in flight at most: index 0 newest, 1 previous
  int    expI [2][PHASES];
  int    expQ [2][PHASES];
  int    tk [2];
  int    lim [2];
  bit    act [2];
  string tag [2];

  task automatic check(string req, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int sx(logic [OUT_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int modelSum(int p, bit q);
    int s = 0;
    for (int k = 0; k < TAP_NUM; k++) begin
      bit v = q ? mvQ[k] : mvI[k];
      bit b = q ? mbQ[k] : mbI[k];
      s += ramM[k][(int'(v) << 3) | (p << 1) | int'(b)];
    end
    return s;
  endfunction

  // R6: I phase p at tick 9+10p, Q at 14+10p; slot ends 4 ticks earlier
  task automatic checkSet(int s);
    int t;
    if (!act[s]) return;
    t = tk[s];
    if (t > 44) begin act[s] = 0; return; end
    if (t - 4 > lim[s]) return;
    if (t >= 9 && (t - 9) % 10 == 0) begin
      check({tag[s], " I sample"}, sx(outI), expI[s][(t - 9) / 10]);
      check("R6 no strobe with I", int'(outStb), 0);
    end else if (t >= 14 && (t - 14) % 10 == 0) begin
      check({tag[s], " Q sample"}, sx(outQ), expQ[s][(t - 14) / 10]);
      check("R6 strobe with Q", int'(outStb), 1);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chipStb = 1'b0;
    for (int s = 0; s < 2; s++) if (act[s]) tk[s]++;
    checkSet(0);
    checkSet(1);
  endtask

  task automatic issue(bit ok, bit ci, bit cq, string t);
    for (int p = 0; p < PHASES; p++) begin
      expI[1][p] = expI[0][p];
      expQ[1][p] = expQ[0][p];
    end
    tk[1] = tk[0]; act[1] = act[0]; lim[1] = tk[0]; tag[1] = tag[0];
    // R5: one stage per new chip
    for (int k = TAP_NUM - 1; k > 0; k--) begin
      mvI[k] = mvI[k-1]; mbI[k] = mbI[k-1];
      mvQ[k] = mvQ[k-1]; mbQ[k] = mbQ[k-1];
    end
    mvI[0] = ok; mbI[0] = ci; mvQ[0] = ok; mbQ[0] = cq;
    for (int p = 0; p < PHASES; p++) begin
      expI[0][p] = modelSum(p, 1'b0);
      expQ[0][p] = modelSum(p, 1'b1);
    end
    tk[0] = 0; lim[0] = 1000; act[0] = 1; tag[0] = t;
    chipOk = ok; chipI = ci; chipQ = cq; chipStb = 1'b1;
  endtask

  task automatic runChip(bit ok, bit ci, bit cq, int gap, string t);
    issue(ok, ci, cq, t);
    repeat (gap) tick();
  endtask

  task automatic flush();
    repeat (50) tick();
  endtask

  // R2 / R10: one coefficient write, mirrored in the model only when enabled
  task automatic progWord(int k, int a, int d, bit en);
    progEn = en;
    progAddr = ADDR_W'(a);
    progData = COEF_W'(d);
    progTapWe = TAP_NUM'(1) << k;
    @(negedge clk);
    progEn = 1'b0;
    progTapWe = '0;
    if (en) ramM[k][a] = d;
  endtask

  // R3: words {valid, phase, chip}: +h for chip 1, -h for chip 0, zero when invalid
  task automatic loadCoefs(int mode);
    for (int k = 0; k < TAP_NUM; k++)
      for (int p = 0; p < PHASES; p++) begin
        int h;
        if (mode == 0) h = int'($urandom_range(4094)) - 2047;
        else h = 2047;
        progWord(k, 8 | (p << 1) | 1, h, 1'b1);
        progWord(k, 8 | (p << 1), -h, 1'b1);
        progWord(k, (p << 1) | 1, 0, 1'b1);
        progWord(k, (p << 1), 0, 1'b1);
      end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 2; s++) begin act[s] = 0; tk[s] = 0; lim[s] = 0; tag[s] = ""; end
    for (int k = 0; k < TAP_NUM; k++) begin
      mvI[k] = 0; mbI[k] = 0; mvQ[k] = 0; mbQ[k] = 0;
      for (int a = 0; a < (1 << ADDR_W); a++) ramM[k][a] = 0;
    end

    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check("R1 outI in reset", sx(outI), 0);
    check("R1 outQ in reset", sx(outQ), 0);
    check("R1 outStb in reset", int'(outStb), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 outI idle", sx(outI), 0);
    check("R1 outQ idle", sx(outQ), 0);
    check("R1 outStb idle", int'(outStb), 0);

    // R2 R3: random coefficients through the programming port
    loadCoefs(0);

    // R3 R4 R5: random valid chips with idle gaps between them
    for (int i = 0; i < 24; i++)
      runChip(1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)), 50, "R3 R4 R5");
    flush();

    // R7: chips every 40 cycles
    for (int i = 0; i < 12; i++)
      runChip(1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)), 40, "R7");
    flush();

    // R8: new chip partway through a frame (tick 22 is mid-slot)
    runChip(1'b1, 1'b1, 1'b0, 22, "R8 cut");
    runChip(1'b1, 1'b0, 1'b1, 20, "R8 cut");
    runChip(1'b1, 1'b1, 1'b1, 50, "R8 restart");
    flush();

    // R9: invalid chips mixed in, then a full line of invalid chips
    runChip(1'b0, 1'b1, 1'b0, 50, "R9 mixed");
    runChip(1'b1, 1'b0, 1'b0, 50, "R9 mixed");
    for (int i = 0; i < TAP_NUM; i++)
      runChip(1'b0, 1'($urandom_range(1)), 1'($urandom_range(1)), 45, "R9 all invalid");
    flush();
    check("R9 zero I after invalid line", sx(outI), 0);
    check("R9 zero Q after invalid line", sx(outQ), 0);

    // R10: writes without programming mode must change nothing
    for (int k = 0; k < TAP_NUM; k++)
      for (int a = 0; a < (1 << ADDR_W); a++)
        progWord(k, a, int'($urandom_range(4094)) - 2047, 1'b0);
    for (int i = 0; i < 14; i++)
      runChip(1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)), 45, "R10");
    flush();

    // R11: full-scale coefficients, all chips +1 on I and -1 on Q
    loadCoefs(1);
    for (int i = 0; i < TAP_NUM; i++) runChip(1'b1, 1'b1, 1'b0, 45, "R11");
    flush();
    check("R11 full-scale I", sx(outI), 12 * 2047);
    check("R11 full-scale Q", sx(outQ), -12 * 2047);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule